// File: doc/BRIEF.md
# FSK Frequency-Centring Controller

This block keeps a narrow receive channel centred on an FSK transmission whose carrier is offset from nominal. A demodulator feeds it signed instantaneous-frequency samples, one unit per kHz, and an activity flag. While searching, the block watches for alternating high and low tones at the start of a packet. It records the highest and lowest samples it sees. After enough tone changes it waits a fixed settle time, then publishes the midpoint of those extremes as a signed correction word for the mixer.

Once locked, the correction stays frozen. When activity stops, a hold window starts. If a retransmission arrives inside that window, the same correction is used again and the window is re-armed. After a full window of silence the block searches afresh. Pulling the enable input low zeroes the correction and stops any search.

All timing runs from a microsecond tick taken from the system clock by a prescaler.

Top module: `fsk_afc_ctrl`

## Requirements
- R1: After reset `lock_o` is 0 and `corr_o` is 0.
- R2: In search, a valid sample counts as a tone change when its distance from the previous valid sample is at least STEP_MIN. A smaller step is not counted. Search completes after 2*PAIRS-1 counted changes, which is six alternating samples for three pairs. Until then the block does not lock.
- R3: After search completes, the block waits SETTLE_US microsecond ticks and then enters the locked state. `lock_o` is 0 throughout search and settle, and is 1 in the locked and hold states.
- R4: The new correction is floor((max+min)/2) of the valid samples taken during the current search.
- R5: The correction is saturated to the range -CORR_LIM..+CORR_LIM.
- R6: While enabled, the correction word changes only at the moment settle ends. Samples taken while locked do not alter it.
- R7: When activity drops while locked, `lock_o` stays 1 and the correction is kept for HOLD_US microseconds.
- R8: Activity during the hold window returns the block to the locked state. The next drop of activity starts a fresh full hold window.
- R9: When the hold window expires, `lock_o` falls and the last correction remains on `corr_o`. A following acquisition replaces it.
- R10: While `afc_en_i` is 0, `corr_o` reads 0 in the same cycle and the stored correction clears. `lock_o` is 0 from the next clock, and no search runs.
- R11: A search that is still incomplete after SEARCH_MAX_US microseconds is abandoned, as is a search or settle that loses activity. The extremes collected so far are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (CLK_PER_US cycles per microsecond) |
| rst_n | input | 1 | Asynchronous active-low reset |
| afc_en_i | input | 1 | Enables centring; 0 forces zero correction |
| sig_act_i | input | 1 | Signal-activity flag from the receive chain |
| samp_vld_i | input | 1 | Frequency sample strobe |
| samp_i | input | SAMP_W | Signed instantaneous frequency, kHz per LSB |
| corr_o | output | CORR_W | Signed frequency correction word |
| lock_o | output | 1 | High in the locked and hold states |

## Verification
A sample presented with its strobe is registered by the tone tracker at the next edge. The state machine reacts one edge later, so search completion is seen two clocks after the last sample. Lock and the new correction then follow up to SETTLE_US ticks later, and the bench checks them after a margin of several ticks past that bound. Checks made while settle is still running confirm the lock is still low. Hold-window checks are placed well inside or well beyond HOLD_US worth of clocks, never near the boundary tick. The zeroing on disable is combinational and is sampled one time step after the input changes; the lock drop is sampled one full clock later.

// File: rtl/afc_pkg.sv
package afc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEARCH,
    ST_SETTLE,
    ST_LOCKED,
    ST_HOLD
  } afc_state_e;

  // Magnitude of the step between two frequency samples.
  function automatic int step_size(input int a, input int b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  // Floor of the average of the two extremes.
  function automatic int midpoint(input int hi, input int lo);
    return (hi + lo) >>> 1;
  endfunction

  // Symmetric saturation to +/- lim.
  function automatic int clamp(input int v, input int lim);
    if (v > lim)  return lim;
    if (v < -lim) return -lim;
    return v;
  endfunction

endpackage

// File: rtl/afc_tick.sv
module afc_tick #(
  parameter int CLK_PER_US = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  generate
    if (CLK_PER_US <= 1) begin : g_pass
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(CLK_PER_US);
      logic [CW-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           div_q <= '0;
        else if (div_q == CW'(CLK_PER_US-1))  div_q <= '0;
        else                                  div_q <= div_q + 1'b1;
      end
      assign tick_o = (div_q == CW'(CLK_PER_US-1));
    end
  endgenerate
endmodule

// File: rtl/afc_tone_tracker.sv
module afc_tone_tracker #(
  parameter int SAMP_W   = 12,
  parameter int STEP_MIN = 20,
  parameter int CHANGES  = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run_i,
  input  logic                     vld_i,
  input  logic signed [SAMP_W-1:0] samp_i,
  output logic signed [SAMP_W-1:0] max_o,
  output logic signed [SAMP_W-1:0] min_o,
  output logic                     done_o
);
  localparam int NW = $clog2(CHANGES + 1);

  logic                     have_q;
  logic signed [SAMP_W-1:0] prev_q;
  logic [NW-1:0]            chg_q;
  logic                     big_step;

  assign big_step = afc_pkg::step_size(int'(samp_i), int'(prev_q)) >= STEP_MIN;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q <= 1'b0;
      prev_q <= '0;
      max_o  <= '0;
      min_o  <= '0;
      chg_q  <= '0;
    end else if (!run_i) begin
      have_q <= 1'b0;
      chg_q  <= '0;
    end else if (vld_i) begin
      prev_q <= samp_i;
      if (!have_q) begin
        have_q <= 1'b1;
        max_o  <= samp_i;
        min_o  <= samp_i;
      end else begin
        if (samp_i > max_o) max_o <= samp_i;
        if (samp_i < min_o) min_o <= samp_i;
        if (big_step && chg_q != NW'(CHANGES)) chg_q <= chg_q + 1'b1;
      end
    end
  end

  assign done_o = (chg_q == NW'(CHANGES));
endmodule

// File: rtl/fsk_afc_ctrl.sv
module fsk_afc_ctrl #(
  parameter int CLK_PER_US    = 16,
  parameter int SAMP_W        = 12,
  parameter int CORR_W        = 10,
  parameter int CORR_LIM      = 200,
  parameter int STEP_MIN      = 20,
  parameter int PAIRS         = 3,
  parameter int SETTLE_US     = 700,
  parameter int SEARCH_MAX_US = 600,
  parameter int HOLD_US       = 200000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     afc_en_i,
  input  logic                     sig_act_i,
  input  logic                     samp_vld_i,
  input  logic signed [SAMP_W-1:0] samp_i,
  output logic signed [CORR_W-1:0] corr_o,
  output logic                     lock_o
);
  import afc_pkg::*;

  localparam int CHANGES = 2 * PAIRS - 1;
  localparam int TMAX_A  = (SETTLE_US > SEARCH_MAX_US) ? SETTLE_US : SEARCH_MAX_US;
  localparam int TMAX    = (HOLD_US > TMAX_A) ? HOLD_US : TMAX_A;
  localparam int TW      = $clog2(TMAX + 1);

  afc_state_e               state_q, state_d;
  logic [TW-1:0]            tmr_q;
  logic signed [CORR_W-1:0] corr_q;
  logic signed [SAMP_W-1:0] tone_max, tone_min;

  // Named internal events
  logic tick, search_done, settle_done, search_tmo, hold_done, leave_settle;

  afc_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_o(tick)
  );

  afc_tone_tracker #(.SAMP_W(SAMP_W), .STEP_MIN(STEP_MIN), .CHANGES(CHANGES)) u_trk (
    .clk(clk), .rst_n(rst_n), .run_i(state_q == ST_SEARCH),
    .vld_i(samp_vld_i), .samp_i(samp_i),
    .max_o(tone_max), .min_o(tone_min), .done_o(search_done)
  );

  assign settle_done = tick && tmr_q == TW'(SETTLE_US - 1);
  assign search_tmo  = tick && tmr_q == TW'(SEARCH_MAX_US - 1);
  assign hold_done   = tick && tmr_q == TW'(HOLD_US - 1);

  always_comb begin
    state_d = state_q;
    if (!afc_en_i) state_d = ST_IDLE;
    else begin
      unique case (state_q)
        ST_IDLE:   if (sig_act_i) state_d = ST_SEARCH;
        ST_SEARCH: if (!sig_act_i || search_tmo) state_d = ST_IDLE;
                   else if (search_done)         state_d = ST_SETTLE;
        ST_SETTLE: if (!sig_act_i)               state_d = ST_IDLE;
                   else if (settle_done)         state_d = ST_LOCKED;
        ST_LOCKED: if (!sig_act_i)               state_d = ST_HOLD;
        ST_HOLD:   if (sig_act_i)                state_d = ST_LOCKED;
                   else if (hold_done)           state_d = ST_IDLE;
        default:   state_d = ST_IDLE;
      endcase
    end
  end

  assign leave_settle = (state_q == ST_SETTLE) && (state_d == ST_LOCKED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tmr_q   <= '0;
      corr_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_d != state_q || state_q == ST_IDLE || state_q == ST_LOCKED) tmr_q <= '0;
      else if (tick) tmr_q <= tmr_q + 1'b1;
      if (!afc_en_i) corr_q <= '0;
      else if (leave_settle)
        corr_q <= CORR_W'(clamp(midpoint(int'(tone_max), int'(tone_min)), CORR_LIM));
    end
  end

  assign corr_o = afc_en_i ? corr_q : '0;
  assign lock_o = (state_q == ST_LOCKED) || (state_q == ST_HOLD);

  // Assertions
  p_dis_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !afc_en_i |=> (corr_q == '0 && !lock_o));

  p_corr_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (afc_en_i && state_q != ST_SETTLE) |=> $stable(corr_q));

  p_corr_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($signed(corr_q) <= CORR_LIM) && ($signed(corr_q) >= -CORR_LIM));

  p_lock_after_settle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> $past(state_q) == ST_SETTLE);

  p_hold_rearm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && afc_en_i && sig_act_i) |=> state_q == ST_LOCKED);

  p_search_gone_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SEARCH && !sig_act_i) |=> state_q == ST_IDLE);
endmodule

// File: tb/sim_fsk_afc_ctrl.sv
module sim_fsk_afc_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int LIM = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, act = 1'b0, vld = 1'b0;
  logic signed [11:0] samp = '0;
  logic signed [9:0]  corr;
  logic               lock;
  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fsk_afc_ctrl #(
    .CLK_PER_US(2), .SAMP_W(12), .CORR_W(10), .CORR_LIM(LIM), .STEP_MIN(10),
    .PAIRS(3), .SETTLE_US(4), .SEARCH_MAX_US(40), .HOLD_US(30)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .afc_en_i(en), .sig_act_i(act),
    .samp_vld_i(vld), .samp_i(samp), .corr_o(corr), .lock_o(lock)
  );

  // hi tone, lo tone, expected correction
  localparam int VEC [7][3] = '{
    '{  50,  -50,    0},
    '{ 150,   50,  100},
    '{ -20, -120,  -70},
    '{ 300,  200,  200},
    '{-250, -400, -200},
    '{  31,   -2,   14},
    '{   3,  -10,   -4}
  };

  task automatic chk(input string req, input int actual, input int expect_v);
    n_run++;
    if (actual != expect_v) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expect_v);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send(input int v);
    @(negedge clk); samp = 12'(v); vld = 1'b1;
    @(negedge clk); vld = 1'b0;
  endtask

  task automatic alt(input int hi, input int lo, input int n);
    for (int i = 0; i < n; i++) send((i % 2) ? lo : hi);
  endtask

  task automatic restart();
    @(negedge clk); en = 1'b0; act = 1'b0;
    wait_clk(2); en = 1'b1; act = 1'b1;
    wait_clk(2);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++; n_run++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    wait_clk(3);
    chk("R1 lock", int'(lock), 0);
    chk("R1 corr", int'(corr), 0);
    rst_n = 1'b1;
    wait_clk(2);

    // Table: R4 midpoint and R5 clamp, R3 lock low during settle
    for (int k = 0; k < 7; k++) begin
      restart();
      alt(VEC[k][0], VEC[k][1], 6);
      chk("R3 low in settle", int'(lock), 0);
      wait_clk(14);
      chk("R3 locked", int'(lock), 1);
      chk((k >= 3 && k <= 4) ? "R5 clamp" : "R4 midpoint", int'(corr), VEC[k][2]);
    end

    // R6: samples while locked do not move the correction
    alt(300, -300, 8);
    wait_clk(14);
    chk("R6 frozen", int'(corr), -4);

    // R7 / R8 / R9 hold behaviour (HOLD 30 us = 60 clocks)
    act = 1'b0;
    wait_clk(40);
    chk("R7 hold lock", int'(lock), 1);
    chk("R7 hold corr", int'(corr), -4);
    act = 1'b1; wait_clk(2); act = 1'b0;
    wait_clk(40);
    chk("R8 rearmed", int'(lock), 1);
    wait_clk(40);
    chk("R9 expired", int'(lock), 0);
    chk("R9 corr kept", int'(corr), -4);
    act = 1'b1; wait_clk(2);
    alt(20, -40, 6);
    wait_clk(14);
    chk("R9 reacquire", int'(corr), -10);

    // R2: steps below STEP_MIN not counted
    restart();
    alt(5, -3, 8);
    wait_clk(14);
    chk("R2 small steps", int'(lock), 0);

    // R2: five samples (four changes) not enough, sixth completes
    restart();
    alt(40, -40, 5);
    wait_clk(14);
    chk("R2 four changes", int'(lock), 0);
    send(-40);
    wait_clk(14);
    chk("R2 fifth change", int'(lock), 1);
    chk("R2 corr", int'(corr), 0);

    // R11: timeout discards early extreme
    restart();
    send(400);
    wait_clk(100);
    chk("R11 no lock", int'(lock), 0);
    alt(50, -50, 6);
    wait_clk(14);
    chk("R11 fresh extremes", int'(corr), 0);

    // R11: loss of activity during search aborts
    restart();
    alt(100, 60, 4);
    act = 1'b0; wait_clk(2); act = 1'b1; wait_clk(2);
    alt(-60, -100, 6);
    wait_clk(14);
    chk("R11 abort discard", int'(corr), -80);

    // R10: disable
    @(negedge clk); en = 1'b0;
    #1;
    chk("R10 corr zero", int'(corr), 0);
    @(negedge clk);
    chk("R10 lock low", int'(lock), 0);
    alt(90, -30, 8);
    wait_clk(14);
    chk("R10 no search", int'(lock), 0);
    en = 1'b1; act = 1'b0;
    wait_clk(2);
    chk("R10 stored cleared", int'(corr), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule